// File: doc/BRIEF.md
# Serial-Host Memory Access Port

This block lets an external host reach a 16-bit addressed internal memory space over a four-wire serial link in clock mode 0. While the active-low select line is held low, the host shifts in an 8-bit command byte, then a 16-bit start address, and then streams any number of data bytes. On a write each received byte becomes one write on the local memory bus. On a read each byte fetched from the memory bus is shifted back to the host. The address steps up by one after every byte, so one selection can cover a run of consecutive locations. The address wraps from the top of the space to zero.

Two command bits set the meaning of a transaction. One bit chooses read or write. The other bit chooses whether each write also pulses a notification line to the local processor. The block samples the serial clock, select and data input with the system clock, which must run well above the serial rate. The memory bus strobes therefore come out as ordinary single-cycle system-clock pulses. The serial output has its own enable line, so it can share a wire with other targets. It is enabled only while read data is being returned.

Top module: `spi_mem_port`

## Requirements
- R1: After reset, mem_we, mem_rd and wr_irq are low and spi_miso_oe is low.
- R2: A transaction is 8 command bits, then 16 address bits, then data bytes, all MSB first and all sampled on rising serial clock edges. Command bit 7 selects read (1) or write (0). Command bit 6 set to 1 suppresses write notifications. Command bits 5 to 0 have no effect.
- R3: In a write transaction, each complete data byte produces exactly one single-cycle mem_we pulse. The pulse carries the byte (first bit received in mem_wdata[7]) at mem_addr = start + n, where n is the byte index from 0.
- R4: With command bit 6 at 0, wr_irq pulses in the same cycle as every mem_we. With command bit 6 at 1, wr_irq stays low.
- R5: In a read transaction, a single-cycle mem_rd pulse at the start address follows the last address bit. At the last rising edge of every data byte, a further mem_rd at the next address follows. A read of n bytes therefore issues n+1 requests at start .. start+n.
- R6: mem_rdata is taken in the cycle after mem_rd. The byte read for start + n is shifted out on spi_miso MSB first. spi_miso changes only after a falling serial clock edge, so it is stable at the next rising edge.
- R7: spi_miso_oe is low during the command and address, throughout write transactions, and within three system cycles after select is released. It is high during the data phase of a read, from its first falling serial clock edge.
- R8: Releasing select in the middle of a byte discards that byte: no mem_we, mem_rd or wr_irq comes from it. The next selection starts again at command bit 0.
- R9: The byte address wraps from 16'hFFFF to 16'h0000 during a burst, for both reads and writes.
- R10: mem_we and mem_rd are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host, idle low |
| spi_cs_n | input | 1 | Active-low select from the host |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Output enable for spi_miso (1 = drive) |
| mem_addr | output | 16 | Memory bus address |
| mem_wdata | output | 8 | Memory bus write data |
| mem_we | output | 1 | Single-cycle write strobe |
| mem_rd | output | 1 | Single-cycle read request |
| mem_rdata | input | 8 | Read data, valid in the cycle after mem_rd |
| wr_irq | output | 1 | Single-cycle write notification |

## Verification
The assertions assume that the serial clock stays high and low for at least four system cycles per phase. They also assume that select changes only while the serial clock is low, and that the memory returns data exactly one cycle after each request. Under these assumptions a change of spi_miso always falls inside a low serial clock phase, and the output enable is already off three cycles after select rises. The bench host holds each serial clock phase for five system cycles. It moves the data line and select only during the low phase. A clocked memory model answers every request on the next cycle with a value computed from the address.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_e;

  localparam int unsigned DEF_RD_BIT    = 7;
  localparam int unsigned DEF_NOIRQ_BIT = 6;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/spi_mem_sync.sv
module spi_mem_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic cs_n_i,
  input  logic sdi_i,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_act,
  output logic sdi_s
);

  localparam int unsigned LANES = 3;
  localparam logic [LANES-1:0] IDLE_LANES = 3'b010;

  logic [STAGES-1:0][LANES-1:0] pipe_q, pipe_d;
  logic                         sck_prev_q, sck_prev_d;
  logic [LANES-1:0]             cur;

  assign cur = pipe_q[STAGES-1];

  always_comb begin
    pipe_d     = {pipe_q[STAGES-2:0], {sdi_i, cs_n_i, sck_i}};
    sck_prev_d = cur[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q     <= {STAGES{IDLE_LANES}};
      sck_prev_q <= 1'b0;
    end else begin
      pipe_q     <= pipe_d;
      sck_prev_q <= sck_prev_d;
    end
  end

  assign sck_rise = cur[0] & ~sck_prev_q;
  assign sck_fall = ~cur[0] & sck_prev_q;
  assign cs_act   = ~cur[1];
  assign sdi_s    = cur[2];

endmodule

// File: rtl/spi_mem_frame.sv
module spi_mem_frame
  import spi_mem_pkg::*;
#(
  parameter int unsigned CMD_W     = 8,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned RD_BIT    = DEF_RD_BIT,
  parameter int unsigned NOIRQ_BIT = DEF_NOIRQ_BIT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_rise,
  input  logic              cs_act,
  input  logic              sdi,
  output logic              rd_data_phase,
  output logic              data_bit0,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_rd,
  output logic              wr_irq
);

  localparam int unsigned LONGEST = max3(CMD_W, ADDR_W, DATA_W);
  localparam int unsigned CNT_W   = $clog2(LONGEST + 1);
  localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

  phase_e              phase_q, phase_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [CMD_W-1:0]    cmd_q, cmd_d;
  logic [ADDR_W-2:0]   ash_q, ash_d;
  logic [DATA_W-2:0]   dsh_q, dsh_d;
  logic [ADDR_W-1:0]   cur_q, cur_d;
  logic [ADDR_W-1:0]   maddr_q, maddr_d;
  logic [DATA_W-1:0]   wdata_q, wdata_d;
  logic                we_q, we_d, rd_q, rd_d, irq_q, irq_d;
  logic [ADDR_W-1:0]   addr_full;
  logic [DATA_W-1:0]   byte_full;
  logic [ADDR_W-1:0]   cur_inc;

  assign addr_full = {ash_q, sdi};
  assign byte_full = {dsh_q, sdi};
  assign cur_inc   = cur_q + ADDR_W'(1);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    cmd_d   = cmd_q;
    ash_d   = ash_q;
    dsh_d   = dsh_q;
    cur_d   = cur_q;
    maddr_d = maddr_q;
    wdata_d = wdata_q;
    we_d    = 1'b0;
    rd_d    = 1'b0;
    irq_d   = 1'b0;
    if (!cs_act) begin
      phase_d = PH_CMD;
      cnt_d   = '0;
    end else if (sck_rise) begin
      unique case (phase_q)
        PH_CMD: begin
          cmd_d = {cmd_q[CMD_W-2:0], sdi};
          if (cnt_q == CMD_LAST) begin
            phase_d = PH_ADDR;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        PH_ADDR: begin
          ash_d = addr_full[ADDR_W-2:0];
          if (cnt_q == ADDR_LAST) begin
            phase_d = PH_DATA;
            cnt_d   = '0;
            cur_d   = addr_full;
            if (cmd_q[RD_BIT]) begin
              rd_d    = 1'b1;
              maddr_d = addr_full;
            end
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        PH_DATA: begin
          dsh_d = byte_full[DATA_W-2:0];
          if (cnt_q == DATA_LAST) begin
            cnt_d = '0;
            cur_d = cur_inc;
            if (cmd_q[RD_BIT]) begin
              rd_d    = 1'b1;
              maddr_d = cur_inc;
            end else begin
              we_d    = 1'b1;
              maddr_d = cur_q;
              wdata_d = byte_full;
              irq_d   = ~cmd_q[NOIRQ_BIT];
            end
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        default: begin
          phase_d = PH_CMD;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_CMD;
      cnt_q   <= '0;
      cmd_q   <= '0;
      ash_q   <= '0;
      dsh_q   <= '0;
      cur_q   <= '0;
      maddr_q <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
      rd_q    <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      cmd_q   <= cmd_d;
      ash_q   <= ash_d;
      dsh_q   <= dsh_d;
      cur_q   <= cur_d;
      maddr_q <= maddr_d;
      wdata_q <= wdata_d;
      we_q    <= we_d;
      rd_q    <= rd_d;
      irq_q   <= irq_d;
    end
  end

  assign rd_data_phase = cs_act & (phase_q == PH_DATA) & cmd_q[RD_BIT];
  assign data_bit0     = (cnt_q == '0);
  assign mem_addr      = maddr_q;
  assign mem_wdata     = wdata_q;
  assign mem_we        = we_q;
  assign mem_rd        = rd_q;
  assign wr_irq        = irq_q;

endmodule

// File: rtl/spi_mem_tx.sv
module spi_mem_tx #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              sck_fall,
  input  logic              drive_en,
  input  logic              byte_start,
  input  logic              rd_req,
  input  logic [DATA_W-1:0] rdata,
  output logic              sdo,
  output logic              sdo_oe
);

  logic              wait_q, wait_d;
  logic [DATA_W-1:0] hold_q, hold_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              sdo_q, sdo_d;
  logic              oe_q, oe_d;
  logic [DATA_W-1:0] src;

  assign src = byte_start ? hold_q : sh_q;

  always_comb begin
    wait_d = rd_req;
    hold_d = hold_q;
    sh_d   = sh_q;
    sdo_d  = sdo_q;
    oe_d   = oe_q;
    if (wait_q) begin
      hold_d = rdata;
    end
    if (!cs_act) begin
      oe_d  = 1'b0;
      sdo_d = 1'b0;
    end else if (sck_fall && drive_en) begin
      oe_d  = 1'b1;
      sdo_d = src[DATA_W-1];
      sh_d  = {src[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= 1'b0;
      hold_q <= '0;
      sh_q   <= '0;
      sdo_q  <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      wait_q <= wait_d;
      hold_q <= hold_d;
      sh_q   <= sh_d;
      sdo_q  <= sdo_d;
      oe_q   <= oe_d;
    end
  end

  assign sdo    = sdo_q;
  assign sdo_oe = oe_q;

endmodule

// File: rtl/spi_mem_port.sv
module spi_mem_port
  import spi_mem_pkg::*;
#(
  parameter int unsigned CMD_W       = 8,
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RD_BIT      = DEF_RD_BIT,
  parameter int unsigned NOIRQ_BIT   = DEF_NOIRQ_BIT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_rd,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              wr_irq
);

  logic sck_rise, sck_fall, cs_act, sdi_s;
  logic rd_data_phase, data_bit0;

  spi_mem_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck_i    (spi_sck),
    .cs_n_i   (spi_cs_n),
    .sdi_i    (spi_mosi),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .cs_act   (cs_act),
    .sdi_s    (sdi_s)
  );

  spi_mem_frame #(
    .CMD_W     (CMD_W),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .RD_BIT    (RD_BIT),
    .NOIRQ_BIT (NOIRQ_BIT)
  ) u_frame (
    .clk           (clk),
    .rst_n         (rst_n),
    .sck_rise      (sck_rise),
    .cs_act        (cs_act),
    .sdi           (sdi_s),
    .rd_data_phase (rd_data_phase),
    .data_bit0     (data_bit0),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .mem_we        (mem_we),
    .mem_rd        (mem_rd),
    .wr_irq        (wr_irq)
  );

  spi_mem_tx #(
    .DATA_W (DATA_W)
  ) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_act     (cs_act),
    .sck_fall   (sck_fall),
    .drive_en   (rd_data_phase),
    .byte_start (data_bit0),
    .rd_req     (mem_rd),
    .rdata      (mem_rdata),
    .sdo        (spi_miso),
    .sdo_oe     (spi_miso_oe)
  );

endmodule

// File: rtl/spi_mem_port_chk.sv
module spi_mem_port_chk (
  input logic clk,
  input logic rst_n,
  input logic spi_sck,
  input logic spi_cs_n,
  input logic spi_miso,
  input logic spi_miso_oe,
  input logic mem_we,
  input logic mem_rd,
  input logic wr_irq
);

  logic [1:0] idle_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_cnt_q <= 2'd0;
    end else if (!spi_cs_n) begin
      idle_cnt_q <= 2'd0;
    end else if (idle_cnt_q != 2'd3) begin
      idle_cnt_q <= idle_cnt_q + 2'd1;
    end
  end

  // R10
  bus_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_we, mem_rd}));

  // R4
  irq_with_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_irq |-> mem_we);

  // R3
  we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  // R5
  rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);

  // R7
  we_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !spi_miso_oe);

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_cnt_q == 2'd3) |-> (!spi_miso_oe && !mem_we && !mem_rd && !wr_irq));

  // R6
  miso_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_miso_oe && !$stable(spi_miso)) |-> !spi_sck);

endmodule

bind spi_mem_port spi_mem_port_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .spi_sck     (spi_sck),
  .spi_cs_n    (spi_cs_n),
  .spi_miso    (spi_miso),
  .spi_miso_oe (spi_miso_oe),
  .mem_we      (mem_we),
  .mem_rd      (mem_rd),
  .wr_irq      (wr_irq)
);

// File: tb/tb_spi_mem_port.sv
`timescale 1ns/1ps
module tb_spi_mem_port;

  localparam int H = 5;

  logic        clk;
  logic        rst_n;
  logic        spi_sck;
  logic        spi_cs_n;
  logic        spi_mosi;
  logic        spi_miso;
  logic        spi_miso_oe;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_we;
  logic        mem_rd;
  logic [7:0]  mem_rdata;
  logic        wr_irq;

  spi_mem_port dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .spi_sck     (spi_sck),
    .spi_cs_n    (spi_cs_n),
    .spi_mosi    (spi_mosi),
    .spi_miso    (spi_miso),
    .spi_miso_oe (spi_miso_oe),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_we      (mem_we),
    .mem_rd      (mem_rd),
    .mem_rdata   (mem_rdata),
    .wr_irq      (wr_irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  function automatic logic [7:0] mval(input logic [15:0] a);
    return a[7:0] ^ {a[14:8], a[15]} ^ 8'h5A;
  endfunction

  // memory model: answers one cycle after each request
  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mval(mem_addr);
    else        mem_rdata <= 8'hE7;
  end

  // bus monitor
  logic [15:0] we_addr [0:7];
  logic [7:0]  we_data [0:7];
  logic        we_irq  [0:7];
  logic [15:0] rd_addr [0:7];
  int we_n, rd_n, both_n, orphan_irq;
  int hdr_oe_err, wr_oe_err, rd_oe_err;
  bit in_hdr, in_wr, in_rd;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we) begin
        if (we_n < 8) begin
          we_addr[we_n] = mem_addr;
          we_data[we_n] = mem_wdata;
          we_irq[we_n]  = wr_irq;
        end
        we_n++;
      end
      if (mem_rd) begin
        if (rd_n < 8) rd_addr[rd_n] = mem_addr;
        rd_n++;
      end
      if (mem_we && mem_rd) both_n++;
      if (wr_irq && !mem_we) orphan_irq++;
      if (in_hdr && spi_miso_oe) hdr_oe_err++;
      if (in_wr && spi_miso_oe) wr_oe_err++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_log();
    we_n = 0; rd_n = 0; both_n = 0; orphan_irq = 0;
    hdr_oe_err = 0; wr_oe_err = 0; rd_oe_err = 0;
  endtask

  task automatic send_bit(input logic b, output logic r);
    @(negedge clk);
    spi_mosi = b;
    repeat (H) @(negedge clk);
    r = spi_miso;
    if (in_rd && !spi_miso_oe) rd_oe_err++;
    spi_sck = 1'b1;
    repeat (H) @(negedge clk);
    spi_sck = 1'b0;
  endtask

  logic [7:0] tx_bytes [0:7];
  logic [7:0] rx_bytes [0:7];

  task automatic spi_txn(input logic [7:0] cmd, input logic [15:0] addr,
                         input int nbytes, input int extra_bits, input int hdr_bits);
    logic [23:0] hdr;
    logic        r;
    hdr = {cmd, addr};
    @(negedge clk);
    spi_cs_n = 1'b0;
    repeat (H) @(negedge clk);
    in_hdr = 1'b1;
    for (int i = 0; i < hdr_bits; i++) send_bit(hdr[23-i], r);
    in_hdr = 1'b0;
    if (hdr_bits == 24) begin
      in_wr = ~cmd[7];
      in_rd = cmd[7];
      for (int b = 0; b < nbytes; b++) begin
        for (int k = 0; k < 8; k++) begin
          send_bit(cmd[7] ? 1'b0 : tx_bytes[b][7-k], r);
          rx_bytes[b][7-k] = r;
        end
      end
      for (int k = 0; k < extra_bits; k++) send_bit(k[0], r);
    end
    repeat (H) @(negedge clk);
    spi_cs_n = 1'b1;
    in_wr = 1'b0;
    in_rd = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  logic [15:0] starts [0:3];

  initial begin
    starts[0] = 16'h0000; starts[1] = 16'h1234;
    starts[2] = 16'h7FFE; starts[3] = 16'hFFFD;
    rst_n = 1'b0; spi_sck = 1'b0; spi_cs_n = 1'b1; spi_mosi = 1'b0;
    in_hdr = 1'b0; in_wr = 1'b0; in_rd = 1'b0;
    clear_log();
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(!mem_we && !mem_rd && !wr_irq, "R1", "strobes in reset",
        {mem_we, mem_rd, wr_irq}, 0);
    chk(!spi_miso_oe, "R1", "miso_oe in reset", spi_miso_oe, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!mem_we && !mem_rd && !wr_irq && !spi_miso_oe, "R1", "idle after reset",
        {mem_we, mem_rd, wr_irq, spi_miso_oe}, 0);

    // R2 R3 R4 R9: write sweep
    for (int s = 0; s < 4; s++) begin
      for (int n = 1; n <= 4; n++) begin
        for (int q = 0; q < 2; q++) begin
          logic [7:0] cmd;
          cmd = {1'b0, q[0], 6'(s * 13 + n * 7 + q)};
          for (int b = 0; b < n; b++) tx_bytes[b] = 8'(s * 29 + b * 41 + n * 3 + 7);
          clear_log();
          spi_txn(cmd, starts[s], n, 0, 24);
          chk(we_n == n, "R3", "write strobe count", we_n, n);
          chk(rd_n == 0, "R2", "no reads on write cmd", rd_n, 0);
          for (int b = 0; b < n; b++) begin
            logic [15:0] ea;
            ea = starts[s] + 16'(b);
            chk(we_addr[b] == ea, (ea < starts[s]) ? "R9" : "R3", "write addr",
                we_addr[b], ea);
            chk(we_data[b] == tx_bytes[b], "R3", "write data", we_data[b], tx_bytes[b]);
            chk(we_irq[b] == ~q[0], "R4", "irq with write", we_irq[b], ~q[0]);
          end
          chk(orphan_irq == 0, "R4", "irq without write", orphan_irq, 0);
          chk(wr_oe_err == 0 && hdr_oe_err == 0, "R7", "miso_oe during write",
              wr_oe_err + hdr_oe_err, 0);
          chk(!spi_miso_oe, "R7", "miso_oe after release", spi_miso_oe, 0);
        end
      end
    end

    // R2 R5 R6 R9: read sweep
    for (int s = 0; s < 4; s++) begin
      for (int n = 1; n <= 4; n++) begin
        logic [7:0] cmd;
        cmd = {1'b1, 7'(s * 37 + n * 5)};
        clear_log();
        spi_txn(cmd, starts[s], n, 0, 24);
        chk(rd_n == n + 1, "R5", "read request count", rd_n, n + 1);
        chk(we_n == 0, "R2", "no writes on read cmd", we_n, 0);
        for (int i = 0; i <= n; i++) begin
          logic [15:0] ea;
          ea = starts[s] + 16'(i);
          chk(rd_addr[i] == ea, (ea < starts[s]) ? "R9" : "R5", "read addr",
              rd_addr[i], ea);
        end
        for (int b = 0; b < n; b++) begin
          logic [15:0] ea;
          ea = starts[s] + 16'(b);
          chk(rx_bytes[b] == mval(ea), "R6", "read byte on miso", rx_bytes[b], mval(ea));
        end
        chk(hdr_oe_err == 0, "R7", "miso_oe during header", hdr_oe_err, 0);
        chk(rd_oe_err == 0, "R7", "miso_oe low in read data", rd_oe_err, 0);
        chk(!spi_miso_oe, "R7", "miso_oe after read release", spi_miso_oe, 0);
        chk(both_n == 0, "R10", "we and rd together", both_n, 0);
      end
    end

    // R8: abort inside a data byte
    for (int e = 1; e < 8; e += 3) begin
      tx_bytes[0] = 8'hA1; tx_bytes[1] = 8'h3C;
      clear_log();
      spi_txn(8'h00, 16'h0420, 2, e, 24);
      chk(we_n == 2, "R8", "partial byte discarded", we_n, 2);
      chk(orphan_irq == 0, "R8", "no irq from partial byte", orphan_irq, 0);
    end
    clear_log();
    spi_txn(8'h80, 16'h0510, 1, 5, 24);
    chk(rd_n == 2, "R8", "partial read byte adds no request", rd_n, 2);

    // R8: abort inside the header, then a clean write
    clear_log();
    spi_txn(8'h00, 16'h5555, 0, 0, 13);
    chk(we_n == 0 && rd_n == 0, "R8", "header abort strobes", we_n + rd_n, 0);
    tx_bytes[0] = 8'h96;
    clear_log();
    spi_txn(8'h00, 16'hABCD, 1, 0, 24);
    chk(we_n == 1, "R8", "fresh frame after abort count", we_n, 1);
    chk(we_addr[0] == 16'hABCD, "R8", "fresh frame addr", we_addr[0], 16'hABCD);
    chk(we_data[0] == 8'h96, "R8", "fresh frame data", we_data[0], 8'h96);
    chk(both_n == 0, "R10", "we and rd together", both_n, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule